// File: doc/BRIEF.md
# Dual-Format Microprogram Sequencer

This block steps through a microprogram held in a control store and decides, one word per clock, which address comes next. Each stored word takes one of two shapes, picked by its top bit. A control word drives the control-signal outputs. It then moves either to the following address or to an entry point computed from the instruction opcode. A branch word carries a condition selector and a jump target. It tests the selected status flag and either jumps or falls through to the following address. While a branch word is current, every control output is held at zero.

The control store is a parameter vector that the surrounding design supplies, so the microprogram is set when the block is built. The datapath that consumes the control signals and produces the flags lies outside the block. The sequencer exposes the address of the current word, so the rest of the chip can follow which microstep is executing. It also raises a marker in every branch cycle, so consumers know that cycle performs no work.

Top module: `useq_vformat`

## Requirements
- R1: A synchronous active-high reset loads the control address register with 0, and `upc_o` reads 0 in the cycle after a reset edge.
- R2: Bit 13 of the current word selects its format (1 = branch, 0 = control), and `branch_cycle_o` equals that bit for the word at `upc_o`.
- R3: For a control word, `ctrl_o` equals bits 11..0 of the word.
- R4: For a branch word, `ctrl_o` is all zeros.
- R5: A control word with bit 12 clear makes the next address the current address plus one.
- R6: A control word with bit 12 set makes the next address the opcode map entry `{opcode_i, 2'b00}`, using the opcode present at the clock edge.
- R7: A branch word whose condition field (bits 12..11) is 00 always jumps to the target held in bits 5..0.
- R8: Condition codes 01, 10 and 11 test `flags_i[0]` (zero), `flags_i[1]` (carry) and `flags_i[2]` (negative); when the tested flag is 1, the next address is the target in bits 5..0.
- R9: A conditional branch whose tested flag is 0 makes the next address the current address plus one.
- R10: Incrementing from address 63 wraps to address 0.
- R11: `upc_o` always shows the address of the word whose fields drive `ctrl_o` and `branch_cycle_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| flags_i | input | 3 | Status flags: bit 0 zero, bit 1 carry, bit 2 negative |
| opcode_i | input | 4 | Instruction opcode used for the map entry |
| ctrl_o | output | 12 | Control signals of the current word |
| upc_o | output | 6 | Current control address |
| branch_cycle_o | output | 1 | High while the current word is a branch word |

## Verification
The bench first runs a directed pattern. In this pattern a zero-flag branch at address 0 is forced taken, so the sequence must pass 62, 63 and then wrap to 0. It is then forced not taken, which separates the taken path from the fall-through path and exercises the wrap. Phases with all flags low and all flags high, and phases with the opcode fixed at 0 and at 15, separate each condition code from the others and check both ends of the opcode map. A long stretch of random flags and opcodes, with occasional resets, walks a pseudo-random control store. It mixes all four condition codes and both next-address choices of control words, and it also checks that reset pulls the sequence back to 0 from anywhere.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W    = 6;
    localparam int UC_W    = 12;
    localparam int UOP_W   = 4;
    localparam int UFLAG_W = 3;
    localparam int UW_W    = UC_W + 2;
    localparam int UDEPTH  = 1 << UA_W;

    typedef enum logic [1:0] {
        CC_ALWAYS = 2'd0,
        CC_ZERO   = 2'd1,
        CC_CARRY  = 2'd2,
        CC_NEG    = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        NX_SEQ   = 2'd0,
        NX_MAP   = 2'd1,
        NX_JUMP  = 2'd2,
        NX_RESET = 2'd3
    } nsel_e;

    typedef struct packed {
        logic             is_branch;
        logic             map_sel;
        cond_e            cond;
        logic [UA_W-1:0]  target;
        logic [UC_W-1:0]  ctrl;
    } uword_t;

    function automatic logic [UW_W-1:0] mk_ctrl(input logic map, input logic [UC_W-1:0] c);
        return {1'b0, map, c};
    endfunction

    function automatic logic [UW_W-1:0] mk_branch(input cond_e cc, input logic [UA_W-1:0] t);
        logic [UW_W-1:0] w;
        w = '0;
        w[UW_W-1] = 1'b1;
        w[UW_W-2 -: 2] = cc;
        w[UA_W-1:0] = t;
        return w;
    endfunction

    function automatic logic [UDEPTH*UW_W-1:0] demo_ucode();
        logic [UDEPTH*UW_W-1:0] img;
        img = '0;
        for (int i = 0; i < UDEPTH; i++) begin
            if ((i % 8) == 7)
                img[i*UW_W +: UW_W] = mk_branch(cond_e'(i / 8 % 4), UA_W'((i + 9) % UDEPTH));
            else if ((i % 8) == 3)
                img[i*UW_W +: UW_W] = mk_ctrl(1'b1, UC_W'(i));
            else
                img[i*UW_W +: UW_W] = mk_ctrl(1'b0, UC_W'(1) << (i % UC_W));
        end
        return img;
    endfunction

endpackage

// File: rtl/ustore.sv
module ustore #(
    parameter int ADDR_W = useq_pkg::UA_W,
    parameter int WORD_W = useq_pkg::UW_W,
    parameter int DEPTH  = 1 << ADDR_W,
    parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign rows[g] = IMAGE[g*WORD_W +: WORD_W];
    end

    assign word_o = rows[addr_i];

endmodule

// File: rtl/uword_split.sv
module uword_split
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    parameter int CTRL_W = UC_W,
    localparam int WORD_W = CTRL_W + 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              is_branch_o,
    output logic              map_sel_o,
    output cond_e             cond_o,
    output logic [ADDR_W-1:0] target_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    logic fmt_bit;

    assign fmt_bit     = word_i[WORD_W-1];
    assign is_branch_o = fmt_bit;
    assign map_sel_o   = ~fmt_bit & word_i[WORD_W-2];
    assign cond_o      = cond_e'(word_i[WORD_W-2 -: 2]);
    assign target_o    = word_i[ADDR_W-1:0];

    always_comb begin
        if (fmt_bit)
            ctrl_o = '0;
        else
            ctrl_o = word_i[CTRL_W-1:0];
    end

    // R4
    branch_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        word_i[WORD_W-1] |-> (ctrl_o == '0));

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    parameter int OPC_W  = UOP_W,
    parameter int FLAG_W = UFLAG_W
) (
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] cur_i,
    input  logic              is_branch_i,
    input  logic              map_sel_i,
    input  cond_e             cond_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [OPC_W-1:0]  opcode_i,
    output nsel_e             sel_o,
    output logic [ADDR_W-1:0] next_o
);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] map_addr;
    logic              taken;

    assign seq_addr = cur_i + 1'b1;

    if (ADDR_W >= OPC_W) begin : g_map_wide
        assign map_addr = {opcode_i, {(ADDR_W-OPC_W){1'b0}}};
    end else begin : g_map_narrow
        assign map_addr = opcode_i[OPC_W-1 -: ADDR_W];
    end

    always_comb begin
        unique case (cond_i)
            CC_ALWAYS: taken = 1'b1;
            CC_ZERO:   taken = flags_i[0];
            CC_CARRY:  taken = flags_i[1];
            CC_NEG:    taken = flags_i[2];
            default:   taken = 1'b0;
        endcase
    end

    always_comb begin
        if (rst_i)
            sel_o = NX_RESET;
        else if (is_branch_i)
            sel_o = taken ? NX_JUMP : NX_SEQ;
        else
            sel_o = map_sel_i ? NX_MAP : NX_SEQ;
    end

    always_comb begin
        unique case (sel_o)
            NX_RESET: next_o = '0;
            NX_JUMP:  next_o = target_i;
            NX_MAP:   next_o = map_addr;
            default:  next_o = seq_addr;
        endcase
    end

endmodule

// File: rtl/useq_vformat.sv
module useq_vformat
    import useq_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    parameter int CTRL_W = UC_W,
    parameter int OPC_W  = UOP_W,
    parameter logic [(1<<ADDR_W)*(CTRL_W+2)-1:0] UCODE = demo_ucode(),
    localparam int WORD_W = CTRL_W + 2,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [UFLAG_W-1:0]  flags_i,
    input  logic [OPC_W-1:0]    opcode_i,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [ADDR_W-1:0]   upc_o,
    output logic                branch_cycle_o
);

    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] car_d;
    logic [WORD_W-1:0] cur_word;
    logic              is_branch;
    logic              map_sel;
    cond_e             cond;
    logic [ADDR_W-1:0] target;
    nsel_e             sel;

    ustore #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH),
        .IMAGE  (UCODE)
    ) u_store (
        .addr_i (car_q),
        .word_o (cur_word)
    );

    uword_split #(
        .ADDR_W (ADDR_W),
        .CTRL_W (CTRL_W)
    ) u_split (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .word_i      (cur_word),
        .is_branch_o (is_branch),
        .map_sel_o   (map_sel),
        .cond_o      (cond),
        .target_o    (target),
        .ctrl_o      (ctrl_o)
    );

    useq_next #(
        .ADDR_W (ADDR_W),
        .OPC_W  (OPC_W),
        .FLAG_W (UFLAG_W)
    ) u_next (
        .rst_i       (rst_i),
        .cur_i       (car_q),
        .is_branch_i (is_branch),
        .map_sel_i   (map_sel),
        .cond_i      (cond),
        .target_i    (target),
        .flags_i     (flags_i),
        .opcode_i    (opcode_i),
        .sel_o       (sel),
        .next_o      (car_d)
    );

    always_ff @(posedge clk_i) begin
        car_q <= car_d;
    end

    assign upc_o          = car_q;
    assign branch_cycle_o = is_branch;

    // R1
    reset_zero_chk: assert property (@(posedge clk_i)
        rst_i |=> (upc_o == '0));

    // R5
    seq_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cur_word[WORD_W-1] && !cur_word[WORD_W-2]) |=>
            (upc_o == ADDR_W'($past(upc_o) + 1'b1)));

    // R7
    always_jump_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_word[WORD_W-1] && cur_word[WORD_W-2 -: 2] == 2'b00) |=>
            (upc_o == $past(cur_word[ADDR_W-1:0])));

    // R9
    zero_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cur_word[WORD_W-1] && cur_word[WORD_W-2 -: 2] == 2'b01 && !flags_i[0]) |=>
            (upc_o == ADDR_W'($past(upc_o) + 1'b1)));

    if (ADDR_W >= OPC_W) begin : g_map_chk
        // R6
        map_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (!cur_word[WORD_W-1] && cur_word[WORD_W-2]) |=>
                (upc_o[ADDR_W-1 -: OPC_W] == $past(opcode_i)));
    end

endmodule

// File: tb/sim_useq_vformat.sv
module sim_useq_vformat;

    localparam int AW = 6;
    localparam int CW = 12;
    localparam int OW = 4;
    localparam int WW = CW + 2;
    localparam int DP = 1 << AW;

    function automatic logic [WW-1:0] tb_word(input int i);
        logic [31:0] h;
        h = (i + 1) * 32'h9E3779B1;
        h = h ^ (h >> 15);
        h = h * 32'h85EBCA6B;
        h = h ^ (h >> 13);
        if (i == 0)       return {1'b1, 2'b01, 5'b0, 6'd62};
        if (i >= 62)      return {1'b0, 1'b0, 12'(h)};
        if (h[20:19] == 2'b00)
            return {1'b1, h[24:23], 5'b0, h[5:0]};
        return {1'b0, (h[22:21] == 2'b00), h[11:0]};
    endfunction

    function automatic logic [DP*WW-1:0] build_tbl();
        logic [DP*WW-1:0] t;
        t = '0;
        for (int i = 0; i < DP; i++) t[i*WW +: WW] = tb_word(i);
        return t;
    endfunction

    localparam logic [DP*WW-1:0] TBL = build_tbl();

    logic          clk;
    logic          rst;
    logic [2:0]    flags;
    logic [OW-1:0] opcode;
    logic [CW-1:0] ctrl;
    logic [AW-1:0] upc;
    logic          brc;

    useq_vformat #(.ADDR_W(AW), .CTRL_W(CW), .OPC_W(OW), .UCODE(TBL)) u0 (
        .clk_i(clk), .rst_i(rst), .flags_i(flags), .opcode_i(opcode),
        .ctrl_o(ctrl), .upc_o(upc), .branch_cycle_o(brc)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int n_wrap = 0;
    int n_map = 0;
    int n_take = 0;
    bit done = 0;
    logic [AW-1:0] m_addr = '0;

    function automatic logic [AW-1:0] model_next(input logic [AW-1:0] a,
                                                  input logic [2:0] f,
                                                  input logic [OW-1:0] op);
        logic [WW-1:0] w;
        logic t;
        w = tb_word(int'(a));
        if (w[WW-1]) begin
            case (w[12:11])
                2'b00:   t = 1'b1;
                2'b01:   t = f[0];
                2'b10:   t = f[1];
                default: t = f[2];
            endcase
            return t ? w[5:0] : AW'(a + 1'b1);
        end
        return w[12] ? {op, 2'b00} : AW'(a + 1'b1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (addr %0d)", tag, act, exp, m_addr);
        end
    endtask

    task automatic check_outs();
        logic [WW-1:0] w;
        w = tb_word(int'(m_addr));
        check("R11 upc", 32'(upc), 32'(m_addr));
        check("R2 branch marker", 32'(brc), 32'(w[WW-1]));
        if (w[WW-1]) check("R4 ctrl zero in branch", 32'(ctrl), 32'd0);
        else         check("R3 ctrl bits", 32'(ctrl), 32'(w[CW-1:0]));
    endtask

    task automatic step(input logic [2:0] f, input logic [OW-1:0] op, input logic r);
        logic [WW-1:0] w;
        logic [AW-1:0] nx;
        flags = f; opcode = op; rst = r;
        w = tb_word(int'(m_addr));
        nx = r ? '0 : model_next(m_addr, f, op);
        if (!r && m_addr == 63 && nx == 0) n_wrap++;
        if (!r && !w[WW-1] && w[12]) n_map++;
        if (!r && w[WW-1] && nx == w[5:0] && nx != AW'(m_addr + 1'b1)) n_take++;
        @(posedge clk);
        @(negedge clk);
        m_addr = nx;
        check_outs();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; flags = '0; opcode = '0;
        @(negedge clk);
        step(3'b000, 4'd0, 1'b1);
        // R1: reset state
        check("R1 reset address", 32'(upc), 32'd0);
        // R8 taken zero branch at 0 -> 62, then R5 to 63, R10 wrap to 0
        step(3'b001, 4'd0, 1'b0);
        check("R8 zero taken", 32'(upc), 32'd62);
        step(3'b000, 4'd0, 1'b0);
        check("R5 increment", 32'(upc), 32'd63);
        step(3'b000, 4'd0, 1'b0);
        check("R10 wrap", 32'(upc), 32'd0);
        // R9: not taken at 0 -> 1
        step(3'b000, 4'd0, 1'b0);
        check("R9 fall through", 32'(upc), 32'd1);
        // flag and opcode corner phases (R6, R7, R8)
        for (int k = 0; k < 60; k++) step(3'b000, 4'd0, 1'b0);
        for (int k = 0; k < 60; k++) step(3'b111, 4'd15, 1'b0);
        for (int k = 0; k < 60; k++) step(3'b000, 4'd15, 1'b0);
        for (int k = 0; k < 60; k++) step(3'b111, 4'd0, 1'b0);
        // random phase with periodic reset
        for (int k = 0; k < 6000; k++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[2:0], r[6:3], (k % 250) == 249);
        end
        // coverage checks: R6 map taken, R7/R8 jumps seen, R10 wrap seen
        check("R6 map words executed", 32'(n_map > 0), 32'd1);
        check("R7 jumps executed", 32'(n_take > 0), 32'd1);
        check("R10 wraps seen", 32'(n_wrap > 0), 32'd1);
        finish_run();
    end

endmodule